// File: doc/BRIEF.md
# Oldest-First Issue Select Tree

This block picks one ready instruction per cycle from an issue window and hands it to a single functional unit. Every window slot raises a request line when its instruction has all operands ready. The slots are kept packed toward index zero, with newer instructions placed at higher indices. Because of this, the lowest-indexed requesting slot is always the oldest ready instruction, and that slot is the one granted.

Selection is built as a tree of four-input cells rather than as one flat priority encoder. In the upward pass, each cell ORs its four child request signals and hands the result to its parent. In the downward pass, the root turns the result into an enable. Each cell passes the enable to exactly one child: the lowest-indexed child that is requesting. The leaf enables form the grant vector. A window of 64 slots needs three tree levels. Window sizes that are not a power of four are padded with slots that never request.

A parameter selects whether the grant and valid outputs are registered. By default they are registered, which gives one cycle of latency. With the parameter cleared, the outputs are taken directly from the tree.

Top module: `issue_select_tree`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: A `grant` bit is high only for a slot whose `req` bit was high in the request vector being answered.
- R3: No slot with a lower index than the granted slot was requesting; index 0 has the highest priority.
- R4: `valid` is high exactly when the answered request vector has at least one bit set; when no bit is set, `grant` is all zeros.
- R5: Whenever the answered request vector is non-zero, exactly one `grant` bit is high.
- R6: With `REG_OUT` = 1, `grant` and `valid` answer the `req` value captured at the previous rising edge of `clk`, and they do not change in response to `req` between edges. With `REG_OUT` = 0, they answer the present `req` with no clock delay.
- R7: Any window size `N` from 1 upward is supported, including sizes that are not a power of four; every slot up to index `N-1` can win.
- R8: While `rst_n` is low, the registered `grant` and `valid` are zero, whatever `req` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| req | input | N | Ready request per window slot; bit 0 is the oldest slot |
| grant | output | N | One-hot selection of the winning slot, or zero |
| valid | output | 1 | High when some slot requested |

## Verification
The hardest cases to reach are the ones that decide between cells on different branches of the tree. Examples are a single request in the last slot of a padded window, or requests that sit in two subtrees whose lower cells have no requesting siblings. Random vectors seldom produce these sparse, subtree-crossing patterns. The stimulus therefore sweeps every request vector of a 16-slot registered instance, and of a 10-slot combinational instance whose tree holds padding. This covers every boundary between cells and subtrees, as well as the padded top slots.

// File: rtl/issue_select_tree.sv
module issue_select_tree #(
  parameter int N       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         valid
);

  localparam int LOG2   = (N <= 1) ? 1 : $clog2(N);
  localparam int LEVELS = (LOG2 + 1) / 2;
  localparam int W      = 1 << (2 * LEVELS);

  logic [W-1:0] leaf_req;
  assign leaf_req = W'(req);

  for (genvar k = 0; k <= LEVELS; k++) begin : lvl
    localparam int NODES = W >> (2 * k);
    logic [NODES-1:0] any_req;
    logic [NODES-1:0] en;

    if (k == 0) begin : g_leaf
      assign any_req = leaf_req;
    end else begin : g_up
      for (genvar j = 0; j < NODES; j++) begin : g_or
        assign any_req[j] = |lvl[k-1].any_req[4*j +: 4];
      end
    end

    if (k == LEVELS) begin : g_root
      assign en = any_req;
    end else begin : g_down
      for (genvar i = 0; i < NODES; i++) begin : g_pick
        localparam int BASE = (i / 4) * 4;
        if (i % 4 == 0) begin : g_first
          assign en[i] = lvl[k+1].en[i/4] & any_req[i];
        end else begin : g_rest
          assign en[i] = lvl[k+1].en[i/4] & any_req[i] & ~(|any_req[i-1:BASE]);
        end
      end
    end
  end

  logic [N-1:0] sel;
  logic         root_any;
  assign sel      = lvl[0].en[N-1:0];
  assign root_any = lvl[LEVELS].any_req[0];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grant <= '0;
        valid <= 1'b0;
      end else begin
        grant <= sel;
        valid <= root_any;
      end
    end
  end else begin : g_comb
    assign grant = sel;
    assign valid = root_any;
  end

endmodule

// File: rtl/issue_select_tree_chk.sv
module issue_select_tree_chk #(
  parameter int N       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic         valid
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $onehot0(grant));

  if (REG_OUT) begin : g_seq
    assert_granted_requested_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (grant & ~$past(req)) == '0);
    assert_oldest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (grant != '0) |-> (((grant - N'(1)) & $past(req)) == '0));
    assert_valid_any_R4: assert property (@(posedge clk) disable iff (!rst_n || !live)
      valid == (|$past(req)));
    assert_grant_present_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (|$past(req)) |-> (grant != '0));
  end else begin : g_cmb
    assert_granted_requested_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (grant & ~req) == '0);
    assert_oldest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (grant != '0) |-> (((grant - N'(1)) & req) == '0));
    assert_valid_any_R4: assert property (@(posedge clk) disable iff (!rst_n || !live)
      valid == (|req));
    assert_grant_present_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
      (|req) |-> (grant != '0));
  end

endmodule

bind issue_select_tree issue_select_tree_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .req  (req),
  .grant(grant),
  .valid(valid)
);

// File: tb/issue_select_tree_test.sv
module issue_select_tree_test;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 16;
  localparam int NB = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] req_a = '0;
  logic [NA-1:0] g_a;
  logic          v_a;
  logic [NB-1:0] req_b = '0;
  logic [NB-1:0] g_b;
  logic          v_b;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_select_tree #(.N(NA), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req(req_a), .grant(g_a), .valid(v_a));

  issue_select_tree #(.N(NB), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .req(req_b), .grant(g_b), .valid(v_b));

  task automatic chk_a(input string tag, input logic [NA-1:0] r);
    logic [NA-1:0] exp_g;
    exp_g = r & (~r + NA'(1));
    vectors++;
    if (g_a !== exp_g || v_a !== (|r)) begin
      miscompares++;
      $display("FAIL %s req=%h grant=%h valid=%b expected grant=%h valid=%b",
               tag, r, g_a, v_a, exp_g, |r);
    end
  endtask

  task automatic chk_b(input string tag, input logic [NB-1:0] r);
    logic [NB-1:0] exp_g;
    exp_g = r & (~r + NB'(1));
    vectors++;
    if (g_b !== exp_g || v_b !== (|r)) begin
      miscompares++;
      $display("FAIL %s req=%h grant=%h valid=%b expected grant=%h valid=%b",
               tag, r, g_b, v_b, exp_g, |r);
    end
  endtask

  initial begin
    logic [NA-1:0] prev;
    req_a = '1;
    req_b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_a("R8 reset holds outputs low", '0);
    rst_n = 1'b1;
    prev = req_a;
    for (int v = 0; v < (1 << NA); v++) begin
      @(negedge clk);
      chk_a("R1 R2 R3 R4 R5 R7 registered sweep", prev);
      req_a = NA'(v);
      if (v < (1 << NB)) req_b = NB'(v);
      #1;
      if (v < 256) chk_a("R6 output held until next edge", prev);
      if (v < (1 << NB)) chk_b("R6 R7 combinational padded sweep", req_b);
      prev = req_a;
    end
    @(negedge clk);
    chk_a("R5 R7 final vector", prev);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule